// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets on-chip logic talk to a small serial EEPROM over a chip-select, shift-clock, data-in and data-out connection. A client hands over one command at a time (an operation code, a word address and, for write-type operations, a data word) through a valid/ready port. The controller then builds the serial frame, derives the shift clock from the system clock with a programmable half-period, drives the frame out one bit per shift clock and, for reads, gathers the returned word. The frame is a start bit, a two-bit opcode and the address. Write-type frames add the data word.

Programming operations (word write, word erase, whole-array erase, whole-array write) leave the memory busy for a self-timed interval. The controller therefore drops chip select for a guaranteed gap, raises it again without clocking and watches data-out until it reads high. Only then does it finish the command. A poll that stays low too long ends the command with a timeout flag. The `wide16` pin selects 16-bit words (one address bit fewer) or 8-bit words (the full address).

Command port rules: a command transfers on a clock where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the controller is idle, and the client holds the command fields steady while `cmd_valid` waits. `wide16` may change only while idle. The response is a single-cycle `rsp_valid` pulse with no back-pressure, so the client must take it when it appears.

Top module: `ee3w_host`

## Requirements
- R1: Each frame begins with a 1 bit, then a two-bit opcode (read 10, write 01, erase 11, special 00), then the address MSB first. The address is `ABITS` bits wide in byte mode (`wide16`=0) and `ABITS-1` bits wide (the low bits of `cmd_addr`) in word mode.
- R2: Special commands send opcode 00, with a sub-code in the two most significant address bits: enable 11, disable 00, erase-all 10, write-all 01. All other address bits are sent as 0.
- R3: Write and write-all frames send the data word MSB first right after the address: 8 bits (`cmd_wdata[7:0]`) in byte mode, 16 bits in word mode.
- R4: A read frame gives one extra shift-clock rising edge whose returned bit is thrown away, then 8 or 16 more. The bit sampled at each of those rises builds the word MSB first, and `rsp_rdata` shows it zero-extended to 16 bits.
- R5: `ee_di` never changes on a clock where `ee_sk` rises, so the memory samples a settled bit.
- R6: `ee_sk` is low whenever `ee_cs` is low. Every high phase and every low phase of `ee_sk` lasts at least `HALF_CYC` clocks.
- R7: Each time `ee_cs` goes low, it stays low for at least `HALF_CYC` clocks before it rises again. This holds both between commands and before a status poll.
- R8: For erase, write, erase-all and write-all, the controller raises `ee_cs` after the gap without clocking and samples `ee_do`. It completes only after sampling a 1, dropping `ee_cs` on the same clock that `rsp_valid` pulses with `rsp_timeout`=0.
- R9: If `ee_do` stays 0 for `POLL_LIMIT` sampled clocks, the controller drops `ee_cs` and pulses `rsp_valid` with `rsp_timeout`=1.
- R10: `cmd_ready` is low from acceptance until the gap after the response ends, and a command offered meanwhile is not taken. Each accepted command produces exactly one single-cycle `rsp_valid` pulse. Read, enable and disable commands complete on the clock `ee_cs` falls after their frame.
- R11: Out of reset, `ee_cs`, `ee_sk` and `rsp_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle and will take a command |
| cmd_op | input | 3 | 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all; 7 acts as disable |
| cmd_addr | input | ABITS | Word address |
| cmd_wdata | input | 16 | Data for write and write-all |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word (zero for other commands) |
| rsp_timeout | output | 1 | Status poll gave up |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Shift clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data / ready level from the memory |

## Verification
The bench builds the controller with `ABITS`=7, `HALF_CYC`=2 and `POLL_LIMIT`=100. The short half-period keeps each frame near a hundred clocks, so reads, writes, erases and whole-array operations fit in both word sizes, in 6-bit and 7-bit address modes. The 40-clock busy time of the bench's memory model sits well inside the 100-clock poll limit, so normal polls repeat many times before finishing. A memory model held busy makes the timeout path reachable within a few hundred clocks.

// File: rtl/ee3w_pkg.sv
`timescale 1ns/1ps
package ee3w_pkg;
  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WEN   = 3'd3,
    CMD_WDIS  = 3'd4,
    CMD_ERALL = 3'd5,
    CMD_WRALL = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLLW,
    ST_POLLS
  } state_e;
endpackage

// File: rtl/ee3w_tick_gen.sv
`timescale 1ns/1ps
module ee3w_tick_gen #(
  parameter int HALF_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = en && (cnt == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (en && !tick) cnt <= cnt + 1'b1;
    else                 cnt <= '0;
  end

  generate
    if (HALF_CYC > 1) begin : g_spacing
      // R6
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ee3w_poll_timer.sv
`timescale 1ns/1ps
module ee3w_poll_timer #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = en && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R9
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < TW'(LIMIT)));
endmodule

// File: rtl/ee3w_frame_gen.sv
`timescale 1ns/1ps
module ee3w_frame_gen
  import ee3w_pkg::*;
#(
  parameter int ABITS = 7,
  parameter int FW    = 3 + ABITS + 16,
  parameter int LW    = 6
) (
  input  logic             wide16,
  input  logic [2:0]       op,
  input  logic [ABITS-1:0] addr,
  input  logic [15:0]      wdata,
  output logic [FW-1:0]    frame,
  output logic [LW-1:0]    tx_len,
  output logic [LW-1:0]    tot_len,
  output logic             is_read,
  output logic             is_prog
);
  logic [1:0]       opc;
  logic [1:0]       sub;
  logic             special;
  logic             has_data;
  logic [ABITS-1:0] aeff;
  logic [15:0]      dword;
  logic [LW-1:0]    n_bits;
  logic [LW-1:0]    w_bits;

  always_comb begin
    opc      = 2'b00;
    sub      = 2'b00;
    special  = 1'b0;
    has_data = 1'b0;
    is_read  = 1'b0;
    is_prog  = 1'b0;
    case (op)
      CMD_READ:  begin opc = 2'b10; is_read = 1'b1; end
      CMD_WRITE: begin opc = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
      CMD_ERASE: begin opc = 2'b11; is_prog = 1'b1; end
      CMD_WEN:   begin special = 1'b1; sub = 2'b11; end
      CMD_ERALL: begin special = 1'b1; sub = 2'b10; is_prog = 1'b1; end
      CMD_WRALL: begin special = 1'b1; sub = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
      default:   begin special = 1'b1; sub = 2'b00; end
    endcase

    if (special) begin
      aeff = {sub, {(ABITS-2){1'b0}}};
      if (wide16) aeff = aeff >> 1;
    end else begin
      aeff = addr;
      if (wide16) aeff[ABITS-1] = 1'b0;
    end

    dword = has_data ? wdata : 16'h0000;

    if (wide16) frame = {1'b1, opc, aeff[ABITS-2:0], dword, 1'b0};
    else        frame = {1'b1, opc, aeff, dword[7:0], 8'h00};

    n_bits  = wide16 ? LW'(ABITS - 1) : LW'(ABITS);
    w_bits  = wide16 ? LW'(16) : LW'(8);
    tx_len  = LW'(3) + n_bits + (has_data ? w_bits : '0);
    tot_len = tx_len + (is_read ? (w_bits + LW'(1)) : '0);
  end
endmodule

// File: rtl/ee3w_host.sv
`timescale 1ns/1ps
module ee3w_host
  import ee3w_pkg::*;
#(
  parameter int ABITS      = 7,
  parameter int HALF_CYC   = 13,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide16,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [ABITS-1:0] cmd_addr,
  input  logic [15:0]      cmd_wdata,
  output logic             rsp_valid,
  output logic [15:0]      rsp_rdata,
  output logic             rsp_timeout,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  localparam int FW = 3 + ABITS + 16;
  localparam int LW = $clog2(FW + 18);

  state_e        st;
  logic [FW-1:0] sreg;
  logic [LW-1:0] rise_cnt, tx_len_q, tot_len_q;
  logic          rd_q, prog_q, wide_q, poll_pend;
  logic [15:0]   rx;

  logic [FW-1:0] f_frame;
  logic [LW-1:0] f_tx, f_tot;
  logic          f_rd, f_prog;
  logic          tick, expired;

  ee3w_frame_gen #(.ABITS(ABITS), .FW(FW), .LW(LW)) u_frame (
    .wide16  (wide16),
    .op      (cmd_op),
    .addr    (cmd_addr),
    .wdata   (cmd_wdata),
    .frame   (f_frame),
    .tx_len  (f_tx),
    .tot_len (f_tot),
    .is_read (f_rd),
    .is_prog (f_prog)
  );

  ee3w_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    ((st == ST_SHIFT) || (st == ST_GAP) || (st == ST_POLLW)),
    .tick  (tick)
  );

  ee3w_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st == ST_POLLS),
    .expired (expired)
  );

  assign cmd_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      sreg        <= '0;
      rise_cnt    <= '0;
      tx_len_q    <= '0;
      tot_len_q   <= '0;
      rd_q        <= 1'b0;
      prog_q      <= 1'b0;
      wide_q      <= 1'b0;
      poll_pend   <= 1'b0;
      rx          <= '0;
      ee_cs       <= 1'b0;
      ee_sk       <= 1'b0;
      ee_di       <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            sreg      <= f_frame;
            ee_di     <= f_frame[FW-1];
            ee_cs     <= 1'b1;
            ee_sk     <= 1'b0;
            rise_cnt  <= '0;
            rx        <= '0;
            tx_len_q  <= f_tx;
            tot_len_q <= f_tot;
            rd_q      <= f_rd;
            prog_q    <= f_prog;
            wide_q    <= wide16;
            st        <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!ee_sk) begin
              ee_sk    <= 1'b1;
              rise_cnt <= rise_cnt + 1'b1;
              if (rise_cnt >= tx_len_q) rx <= {rx[14:0], ee_do};
            end else if (rise_cnt == tot_len_q) begin
              ee_sk <= 1'b0;
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
              st    <= ST_GAP;
              if (prog_q) begin
                poll_pend <= 1'b1;
              end else begin
                rsp_valid   <= 1'b1;
                rsp_timeout <= 1'b0;
                rsp_rdata   <= !rd_q ? 16'h0000 :
                               (wide_q ? rx : {8'h00, rx[7:0]});
              end
            end else begin
              ee_sk <= 1'b0;
              sreg  <= sreg << 1;
              ee_di <= sreg[FW-2];
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (poll_pend) begin
              ee_cs     <= 1'b1;
              poll_pend <= 1'b0;
              st        <= ST_POLLW;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_POLLW: begin
          if (tick) st <= ST_POLLS;
        end
        ST_POLLS: begin
          if (ee_do || expired) begin
            ee_cs       <= 1'b0;
            rsp_valid   <= 1'b1;
            rsp_timeout <= !ee_do;
            rsp_rdata   <= 16'h0000;
            st          <= ST_GAP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  // R5
  di_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> $stable(ee_di));

  // R10
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  accept_opens_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (ee_cs && !cmd_ready));

  // R8
  poll_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_POLLW) || (st == ST_POLLS)) |-> (ee_cs && !ee_sk));

  // R8
  rsp_drops_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !ee_cs);
endmodule

// File: tb/sim_ee3w_host.sv
`timescale 1ns/1ps
module sim_ee3w_host;
  localparam int ABITS = 7;
  localparam int HALF  = 2;
  localparam int PLIM  = 100;
  localparam int BUSY  = 40;
  localparam int MSZ   = 1 << ABITS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wide16 = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [2:0]       cmd_op = 3'd0;
  logic [ABITS-1:0] cmd_addr = '0;
  logic [15:0]      cmd_wdata = '0;
  logic             rsp_valid;
  logic [15:0]      rsp_rdata;
  logic             rsp_timeout;
  logic             ee_cs, ee_sk, ee_di;
  logic             ee_do = 1'b0;

  always #10 clk = ~clk;

  ee3w_host #(.ABITS(ABITS), .HALF_CYC(HALF), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .wide16(wide16),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int vecs = 0;
  int bad  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural memory model and protocol observer
  logic [7:0] mem [MSZ];
  bit         s_en, stuck, in_txn;
  int         s_busy, s_rises, frame_cnt, last_len;
  longint     s_bits, last_bits;
  bit         s_dout, poll_seen;
  logic [15:0] s_word;
  bit         p_cs, p_sk, p_di, p_rsp;
  int         sk_run, cs_low;

  always @(negedge clk) begin
    int n, w, op, a, sub, idx;
    n = wide16 ? ABITS - 1 : ABITS;
    w = wide16 ? 16 : 8;
    if (!rst_n) begin
      s_en = 0; s_busy = 0; s_rises = 0; s_bits = 0; s_dout = 0;
      frame_cnt = 0; sk_run = 1000; cs_low = 1000; p_cs = 0; p_sk = 0; p_di = 0; p_rsp = 0;
      ee_do = 1'b0;
    end else begin
      // per-clock protocol comparison
      chk(ee_cs || !ee_sk, "R6 sk with cs low", ee_sk, 0);
      if (ee_sk != p_sk) begin
        chk(sk_run >= HALF, "R6 sk phase length", sk_run, HALF);
        sk_run = 1;
      end else sk_run++;
      if (ee_cs && !p_cs) chk(cs_low >= HALF, "R7 cs low gap", cs_low, HALF);
      if (ee_sk && !p_sk) chk(ee_di == p_di, "R5 di moved at sk rise", ee_di, p_di);
      chk(!(in_txn && cmd_ready), "R10 ready during command", cmd_ready, 0);
      chk(!(rsp_valid && p_rsp), "R10 rsp pulse width", rsp_valid, 0);
      if (!ee_cs) cs_low++; else cs_low = 0;

      // memory model
      if (s_busy > 0) s_busy--;
      if (ee_cs && !p_cs) begin s_rises = 0; s_bits = 0; end
      if (ee_cs && ee_sk && !p_sk) begin
        s_bits = (s_bits << 1) | longint'(ee_di);
        s_rises++;
        if (s_rises >= 3 + n && ((s_bits >> (s_rises - 3)) & 3) == 2) begin
          if (s_rises == 3 + n) begin
            a = int'(s_bits & ((64'd1 << n) - 1));
            s_word = wide16 ? {mem[2*a], mem[2*a+1]} : {8'h00, mem[a]};
            s_dout = 0;
          end else begin
            idx = s_rises - 4 - n;
            s_dout = (idx < w) ? s_word[w-1-idx] : 1'b0;
          end
        end
      end
      if (!ee_cs && p_cs) begin
        if (s_rises == 0) poll_seen = 1;
        else begin
          last_bits = s_bits; last_len = s_rises; frame_cnt++;
          if (s_rises >= 3 + n) begin
            op  = int'((s_bits >> (s_rises - 3)) & 3);
            a   = int'((s_bits >> (s_rises - 3 - n)) & ((64'd1 << n) - 1));
            sub = a >> (n - 2);
            if (op == 0 && sub == 3) s_en = 1;
            else if (op == 0 && sub == 0) s_en = 0;
            else if (s_en && op == 0 && sub == 2) begin
              for (int i = 0; i < MSZ; i++) mem[i] = 8'hFF;
              s_busy = BUSY;
            end else if (s_en && op == 0 && sub == 1 && s_rises == 3 + n + w) begin
              for (int i = 0; i < MSZ; i++)
                mem[i] = wide16 ? ((i % 2 == 0) ? s_bits[15:8] : s_bits[7:0]) : s_bits[7:0];
              s_busy = BUSY;
            end else if (s_en && op == 1 && s_rises == 3 + n + w) begin
              if (wide16) begin mem[2*a] = s_bits[15:8]; mem[2*a+1] = s_bits[7:0]; end
              else mem[a] = s_bits[7:0];
              s_busy = BUSY;
            end else if (s_en && op == 3) begin
              if (wide16) begin mem[2*a] = 8'hFF; mem[2*a+1] = 8'hFF; end
              else mem[a] = 8'hFF;
              s_busy = BUSY;
            end
          end
        end
        s_dout = 0;
      end
      ee_do = ee_cs ? ((s_rises == 0) ? (s_busy == 0 && !stuck) : s_dout) : 1'b0;
      p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di; p_rsp = rsp_valid;
    end
  end

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  function automatic longint exp_frame(input int op, input int a, input int d, output int len);
    int n, w, opc, sub; bit sp, hd; longint f;
    n = wide16 ? ABITS - 1 : ABITS;
    w = wide16 ? 16 : 8;
    sp = 0; hd = 0; opc = 0; sub = 0;
    case (op)
      0: opc = 2;
      1: begin opc = 1; hd = 1; end
      2: opc = 3;
      3: begin sp = 1; sub = 3; end
      4: begin sp = 1; sub = 0; end
      5: begin sp = 1; sub = 2; end
      default: begin sp = 1; sub = 1; hd = 1; end
    endcase
    f = 1;
    f = (f << 2) | longint'(opc);
    f = (f << n) | (sp ? longint'(sub << (n - 2)) : (longint'(a) & ((64'd1 << n) - 1)));
    len = 3 + n;
    if (hd) begin f = (f << w) | (longint'(d) & ((64'd1 << w) - 1)); len += w; end
    return f;
  endfunction

  task automatic issue(input int op, input int a, input int d);
    cmd_op = 3'(op); cmd_addr = ABITS'(a); cmd_wdata = 16'(d); cmd_valid = 1'b1;
    poll_seen = 0;
    while (!cmd_ready) step();
    @(posedge clk); #1;
    in_txn = 1;
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd(input int op, input int a, input int d, input bit chk_rd,
                            input int exp_rd, input bit exp_to);
    int k, len, w; longint ef; bit prog;
    k = 0;
    while (!rsp_valid && k < 4000) begin step(); k++; end
    chk(rsp_valid, "R10 response arrives", rsp_valid, 1);
    in_txn = 0;
    chk(!ee_cs, "R8 cs low with response", ee_cs, 0);
    chk(rsp_timeout == exp_to, exp_to ? "R9 timeout flag" : "R8 no timeout", rsp_timeout, exp_to);
    w = wide16 ? 16 : 8;
    ef = exp_frame(op, a, d, len);
    if (op == 0) begin
      chk(last_len == len + 1 + w, "R4 read rise count", last_len, len + 1 + w);
      chk((last_bits >> (1 + w)) == ef, "R1 read header", last_bits >> (1 + w), ef);
    end else begin
      chk(last_len == len, op >= 3 ? "R2 special length" : "R3 frame length", last_len, len);
      chk(last_bits == ef, op >= 3 ? "R2 special frame" : "R1 frame bits", last_bits, ef);
    end
    if (chk_rd) chk(rsp_rdata == 16'(exp_rd), "R4 read data", rsp_rdata, exp_rd);
    prog = (op == 1 || op == 2 || op == 5 || op == 6);
    if (prog && !exp_to) begin
      chk(poll_seen, "R8 status poll window", poll_seen, 1);
      chk(s_busy == 0, "R8 completion after ready", s_busy, 0);
    end
    if (!prog) chk(!poll_seen, "R10 no poll for non-programming", poll_seen, 0);
    step();
    chk(!rsp_valid, "R10 single pulse", rsp_valid, 0);
  endtask

  task automatic run(input int op, input int a, input int d, input bit chk_rd,
                     input int exp_rd, input bit exp_to);
    issue(op, a, d);
    finish_cmd(op, a, d, chk_rd, exp_rd, exp_to);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int fc;
    for (int i = 0; i < MSZ; i++) mem[i] = 8'hFF;
    stuck = 0; in_txn = 0; poll_seen = 0;
    repeat (3) step();
    // R11 reset values
    chk(!ee_cs && !ee_sk, "R11 cs/sk in reset", {ee_cs, ee_sk}, 0);
    chk(!rsp_valid, "R11 rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    step();
    chk(cmd_ready, "R11 ready after reset", cmd_ready, 1);

    // word mode
    wide16 = 1'b1;
    run(1, 5, 16'h1234, 0, 0, 0);          // R3 write while disabled
    run(0, 5, 0, 1, 16'hFFFF, 0);          // R4 unchanged
    run(3, 0, 0, 0, 0, 0);                 // R2 enable
    run(1, 5, 16'hA5C3, 0, 0, 0);          // R3 R8
    run(0, 5, 0, 1, 16'hA5C3, 0);          // R4 word
    run(1, 63, 16'h8001, 0, 0, 0);
    run(0, 63, 0, 1, 16'h8001, 0);         // R1 top address
    run(2, 5, 0, 0, 0, 0);                 // R8 erase
    run(0, 5, 0, 1, 16'hFFFF, 0);

    // R10 command held during a transaction is not taken
    fc = frame_cnt;
    issue(0, 63, 0);
    cmd_op = 3'd1; cmd_addr = 7'd63; cmd_wdata = 16'h0000; cmd_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!cmd_ready, "R10 busy refuses command", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    finish_cmd(0, 63, 0, 1, 16'h8001, 0);
    chk(frame_cnt == fc + 1, "R10 extra frame", frame_cnt, fc + 1);

    // byte mode
    wide16 = 1'b0;
    step();
    run(1, 7'h7F, 16'h005A, 0, 0, 0);      // R1 R3 byte
    run(0, 7'h7F, 0, 1, 16'h005A, 0);      // R4 byte
    run(1, 7'h12, 16'h00C7, 0, 0, 0);
    run(0, 7'h12, 0, 1, 16'h00C7, 0);
    run(6, 0, 16'h0096, 0, 0, 0);          // R2 write-all byte
    run(0, 7'h33, 0, 1, 16'h0096, 0);

    wide16 = 1'b1;
    step();
    run(6, 0, 16'h0F3C, 0, 0, 0);          // R2 write-all word
    run(0, 0, 0, 1, 16'h0F3C, 0);
    run(0, 40, 0, 1, 16'h0F3C, 0);
    run(5, 0, 0, 0, 0, 0);                 // R2 erase-all
    run(0, 9, 0, 1, 16'hFFFF, 0);
    run(4, 0, 0, 0, 0, 0);                 // R2 disable
    run(1, 2, 16'h1111, 0, 0, 0);
    run(0, 2, 0, 1, 16'hFFFF, 0);

    // R9 timeout
    run(3, 0, 0, 0, 0, 0);
    stuck = 1;
    run(1, 3, 16'h2222, 0, 0, 1);
    stuck = 0;
    run(0, 3, 0, 1, 16'h2222, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule